// File: doc/BRIEF.md
# PWM Interrupt Decimation Counter

This block thins out a stream of carrier-period events so that a motor-control PWM engine raises only one interrupt request every n periods. The reload value n comes from a register interface. Events come from one of two places. One is a timer underflow pulse. The other is a chosen edge of a level signal, the reload-control output of a second timer. Three configuration bits pick the source: a mode bit, a source-select bit and an edge-select bit.

Counting restarts whenever software writes the source-select bit. Software writes that bit after it has written the reload value. From a restart, the first interrupt arrives one event early, after n-1 counted events. Every later interrupt arrives after a full n events. While the surrounding three-phase function is disabled, the counter is held at its start state and stays silent. The output is a registered pulse, one clock wide, for each terminal count.

Top module: `pwm_irq_decimator`

## Requirements
- R1: With ext_mode_i = 0, only uflow_i pulses are counted. edge_sel_i, src_sel_i and rld_ctl_i have no effect on irq_o.
- R2: With ext_mode_i = 1 and src_sel_i = 1 and edge_sel_i = 0, only rising edges of rld_ctl_i are counted. Falling edges and uflow_i are ignored.
- R3: With ext_mode_i = 1 and src_sel_i = 1 and edge_sel_i = 1, only falling edges of rld_ctl_i are counted. Rising edges and uflow_i are ignored.
- R4: With ext_mode_i = 1 and src_sel_i = 0, only uflow_i pulses are counted. rld_ctl_i has no effect.
- R5: After a restart with reload_i = n, where n is 2 to 15, the first interrupt comes on the (n-1)-th counted event.
- R6: After each interrupt, the next one comes after n counted events. n is the reload_i value present at the terminal count, so a change made mid-period takes effect from the following period.
- R7: reload_i = 0 behaves as 1. With 0 or 1, every counted event raises an interrupt, the first one included.
- R8: A cycle with src_wr_i = 1 restarts counting. An event in that same cycle is not counted and raises no interrupt.
- R9: While en_i = 0, no interrupt is raised and events are not counted. After en_i returns to 1, the first interrupt comes after n-1 counted events.
- R10: irq_o is 0 in reset. irq_o is high for exactly one cycle, the cycle after the clock edge that samples the terminal event.
- R11: rld_ctl_i edges are found by comparing the input with its value registered one cycle earlier. This register keeps tracking while the block is disabled, so enabling creates no false edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Three-phase function enable; 0 holds the counter at its start state |
| ext_mode_i | input | 1 | 0 = basic mode, 1 = extended mode |
| edge_sel_i | input | 1 | Extended mode edge: 0 = rising, 1 = falling |
| src_sel_i | input | 1 | Extended mode source: 0 = underflow, 1 = reload-control edge |
| src_wr_i | input | 1 | Write strobe of the source-select bit; restarts counting |
| reload_i | input | 4 | Reload value n (0 treated as 1) |
| uflow_i | input | 1 | Timer underflow pulse, one cycle per event |
| rld_ctl_i | input | 1 | Reload-control level of the second timer |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
A counted event and a restart strobe can land in the same clock cycle. The restart must win, the event must be dropped, and the counter must reload its shortened first period. The bench first brings the model's remaining count to one, so that the event on its own would be terminal. It then raises src_wr_i and uflow_i at the same negative edge. It checks that irq_o stays low on the following cycle, and that exactly n-1 further events are needed for the next interrupt. The same kind of overlap is provoked between a terminal event and en_i falling, and it is judged the same way.

// File: rtl/pwm_idc_pkg.sv
package pwm_idc_pkg;

  // Effective reload: a programmed zero behaves as one.
  function automatic int unsigned eff_reload(input int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

  // Event count of the first period after a start: one short, never below one.
  function automatic int unsigned first_period(input int unsigned n);
    int unsigned e;
    e = eff_reload(n);
    return (e > 1) ? (e - 1) : 1;
  endfunction

endpackage

// File: rtl/pwm_idc_edge_det.sv
module pwm_idc_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic sig_q;

  // Tracks always, even while disabled, so that enabling sees no false edge.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
  assign fall_o = ~sig_i & sig_q;

  AST_RISE_NOT_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);  // R11
  AST_FALL_NOT_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);  // R11
endmodule

// File: rtl/pwm_idc_src_mux.sv
module pwm_idc_src_mux (
  input  logic ext_mode_i,
  input  logic src_sel_i,
  input  logic edge_sel_i,
  input  logic uflow_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic event_o
);
  logic use_edge;
  logic edge_hit;

  always_comb begin
    use_edge = ext_mode_i & src_sel_i;
    edge_hit = edge_sel_i ? fall_i : rise_i;
    event_o  = use_edge ? edge_hit : uflow_i;
  end
endmodule

// File: rtl/pwm_idc_downcnt.sv
module pwm_idc_downcnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic             event_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             term_o,
  output logic             irq_o
);
  import pwm_idc_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] first_ld;
  logic [CNT_W-1:0] period_ld;
  logic             hold;
  logic             irq_q;

  always_comb begin
    first_ld  = CNT_W'(first_period(int'(reload_i)));
    period_ld = CNT_W'(eff_reload(int'(reload_i)));
    hold      = ~en_i | restart_i;
    term_o    = ~hold & event_i & (cnt_q == ONE);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= ONE;
      irq_q <= 1'b0;
    end else begin
      irq_q <= term_o;
      if (hold)          cnt_q <= first_ld;
      else if (event_i)  cnt_q <= (cnt_q == ONE) ? period_ld : (cnt_q - ONE);
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o);  // R9
  AST_RESTART_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !irq_o);  // R8
  AST_CNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0);  // R7
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !restart_i && !event_i) |=> $stable(cnt_q));  // R6
endmodule

// File: rtl/pwm_irq_decimator.sv
module pwm_irq_decimator #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ext_mode_i,
  input  logic             edge_sel_i,
  input  logic             src_sel_i,
  input  logic             src_wr_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             uflow_i,
  input  logic             rld_ctl_i,
  output logic             irq_o
);
  logic             rise_w;
  logic             fall_w;
  logic             event_w;
  logic             term_w;
  logic [CNT_W-1:0] cnt_w;

  pwm_idc_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (rld_ctl_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  pwm_idc_src_mux u_mux (
    .ext_mode_i (ext_mode_i),
    .src_sel_i  (src_sel_i),
    .edge_sel_i (edge_sel_i),
    .uflow_i    (uflow_i),
    .rise_i     (rise_w),
    .fall_i     (fall_w),
    .event_o    (event_w)
  );

  pwm_idc_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .restart_i (src_wr_i),
    .event_i   (event_w),
    .reload_i  (reload_i),
    .cnt_o     (cnt_w),
    .term_o    (term_w),
    .irq_o     (irq_o)
  );

  AST_BASIC_UFLOW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_mode_i |-> (event_w == uflow_i));  // R1
  AST_EDGE_SRC_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_mode_i && src_sel_i && !rise_w && !fall_w) |-> !event_w);  // R2
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(event_w && en_i && !src_wr_i));  // R10
  AST_TERM_AT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_w |-> (cnt_w == CNT_W'(1)));  // R6
endmodule

// File: tb/pwm_irq_decimator_tb_top.sv
module pwm_irq_decimator_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       ext_mode_i = 1'b0;
  logic       edge_sel_i = 1'b0;
  logic       src_sel_i = 1'b0;
  logic       src_wr_i = 1'b0;
  logic [3:0] reload_i = 4'd1;
  logic       uflow_i = 1'b0;
  logic       rld_ctl_i = 1'b0;
  logic       irq_o;

  int checks = 0;
  int failures = 0;
  int rem = 1;

  always #5 clk_i = ~clk_i;

  pwm_irq_decimator dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ext_mode_i(ext_mode_i),
    .edge_sel_i(edge_sel_i), .src_sel_i(src_sel_i), .src_wr_i(src_wr_i),
    .reload_i(reload_i), .uflow_i(uflow_i), .rld_ctl_i(rld_ctl_i), .irq_o(irq_o)
  );

  function automatic int b_period(input int n);
    if (n < 1) return 1;
    return n;
  endfunction

  function automatic int b_first(input int n);
    if (n <= 1) return 1;
    return n - 1;
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s irq_o actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic restart(input int n);
    @(negedge clk_i);
    reload_i = 4'(n);
    src_wr_i = 1'b1;
    @(negedge clk_i);
    src_wr_i = 1'b0;
    rem = b_first(n);
  endtask

  // kind: 0 = underflow pulse, 1 = raise rld_ctl, 2 = lower rld_ctl
  task automatic ev(input int kind, input string req);
    logic counted;
    logic exp;
    @(negedge clk_i);
    if (kind == 0) uflow_i = 1'b1;
    else if (kind == 1) rld_ctl_i = 1'b1;
    else rld_ctl_i = 1'b0;
    if (ext_mode_i && src_sel_i)
      counted = edge_sel_i ? (kind == 2) : (kind == 1);
    else
      counted = (kind == 0);
    counted = counted && en_i;
    exp = 1'b0;
    if (counted) begin
      if (rem == 1) begin exp = 1'b1; rem = b_period(int'(reload_i)); end
      else rem--;
    end
    @(negedge clk_i);
    uflow_i = 1'b0;
    check(irq_o, exp, req);
  endtask

  task automatic t_reset();
    check(irq_o, 1'b0, "R10 reset");
  endtask

  task automatic t_basic();
    ext_mode_i = 0; src_sel_i = 1; edge_sel_i = 1;
    restart(4);
    for (int i = 0; i < 7; i++) begin
      ev(1, "R1 rld ignored"); ev(2, "R1 rld ignored");
      ev(0, "R1/R5/R6 basic underflow");
    end
    @(negedge clk_i);
    check(irq_o, 1'b0, "R10 single cycle");
  endtask

  task automatic t_ext_rise();
    ext_mode_i = 1; src_sel_i = 1; edge_sel_i = 0;
    restart(3);
    for (int i = 0; i < 6; i++) begin
      ev(0, "R2 uflow ignored"); ev(1, "R2 rising"); ev(2, "R2 falling ignored");
    end
  endtask

  task automatic t_ext_fall();
    ext_mode_i = 1; src_sel_i = 1; edge_sel_i = 1;
    restart(3);
    for (int i = 0; i < 6; i++) begin
      ev(1, "R3 rising ignored"); ev(0, "R3 uflow ignored"); ev(2, "R3 falling");
    end
  endtask

  task automatic t_ext_uflow();
    ext_mode_i = 1; src_sel_i = 0; edge_sel_i = 0;
    restart(2);
    for (int i = 0; i < 5; i++) begin
      ev(1, "R4 rld ignored"); ev(0, "R4 underflow"); ev(2, "R4 rld ignored");
    end
  endtask

  task automatic t_small_n();
    ext_mode_i = 0;
    restart(1);
    for (int i = 0; i < 3; i++) ev(0, "R7 n=1 every event");
    restart(0);
    for (int i = 0; i < 3; i++) ev(0, "R7 n=0 as 1");
  endtask

  task automatic t_n15();
    ext_mode_i = 0;
    restart(15);
    for (int i = 0; i < 14 + 15 + 3; i++) ev(0, "R5/R6 n=15");
  endtask

  task automatic t_reload_change();
    ext_mode_i = 0;
    restart(5);
    ev(0, "R6 before change");
    reload_i = 4'd2;
    for (int i = 0; i < 8; i++) ev(0, "R6 reload change next period");
  endtask

  task automatic t_collision();
    ext_mode_i = 0;
    restart(3);
    ev(0, "R8 prep");
    @(negedge clk_i);
    src_wr_i = 1'b1; uflow_i = 1'b1;
    @(negedge clk_i);
    src_wr_i = 1'b0; uflow_i = 1'b0;
    check(irq_o, 1'b0, "R8 restart beats terminal event");
    rem = b_first(3);
    for (int i = 0; i < 5; i++) ev(0, "R8 after restart");
  endtask

  task automatic t_disable();
    ext_mode_i = 0;
    restart(4);
    ev(0, "R9 prep"); ev(0, "R9 prep");
    @(negedge clk_i);
    en_i = 1'b0; uflow_i = 1'b1;
    @(negedge clk_i);
    uflow_i = 1'b0;
    check(irq_o, 1'b0, "R9 disable beats terminal event");
    for (int i = 0; i < 3; i++) ev(0, "R9 disabled no irq");
    rld_ctl_i = 1'b1;
    @(negedge clk_i);
    en_i = 1'b1; ext_mode_i = 1; src_sel_i = 1; edge_sel_i = 0;
    rem = b_first(4);
    ev(2, "R11 fall ignored");
    for (int i = 0; i < 3; i++) begin ev(1, "R9/R11 re-enable"); ev(2, "R9 fall ignored"); end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    en_i = 1'b1;
    t_basic();
    t_ext_rise();
    t_ext_fall();
    t_ext_uflow();
    t_small_n();
    t_n15();
    t_reload_change();
    t_collision();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule